// File: doc/BRIEF.md
# User Counter Offset Unit

This block presents the user-level time, cycle and instret counter registers as though software could write them, while the base counters that feed them keep running undisturbed. Each user view reads as a free-running base value plus an offset held in the block. A write to a view keeps the base counter as it is and stores in the offset the difference between the written value and the current base. Time views are measured against a real-time counter input. The cycle and instret views share one offset, measured against a retired-instruction count input that rises by the number of instructions retired. Two raw machine time views give the real-time counter unchanged. A mode input selects 32-bit or 64-bit register width. In 32-bit mode the low-half and high-half offsets are updated separately. In 64-bit mode the high-half views do not exist.

An access presents a 3-bit view code together with a read/write flag and write data. It is accepted in any cycle. A small state machine records the outcome of the previous cycle. ST_IDLE means no request was made. ST_DONE means a legal access completed, and read data is shown. ST_FAULT means an illegal access was refused. The transitions are the same from every state: a cycle with a legal request goes to ST_DONE, a cycle with an illegal request goes to ST_FAULT, and a cycle with no request goes to ST_IDLE. Reset enters ST_IDLE. The response is valid in ST_DONE and ST_FAULT. All arithmetic wraps modulo 2^64.

View codes: 0 time, 1 time high half, 2 cycle, 3 cycle high half, 4 instret, 5 instret high half, 6 machine time, 7 machine time high half.

Top module: `user_ctr_offset`

## Requirements
- R1: A request (req_valid high at a clock edge) gives exactly one response, with rsp_valid high in the following cycle. Without a request, rsp_valid is low in the following cycle.
- R2: A read of view 0 returns rtc_count plus the time offset. In 64-bit mode (mode32=0) all 64 bits are returned. In 32-bit mode the low 32 bits are returned, zero-extended.
- R3: A write to view 0 or view 2 or view 4 stores (req_wdata - base) in the offset for that view, where base is the counter value at the accepting edge. In 32-bit mode only offset bits 31:0 are replaced, and bits 63:32 are kept.
- R4: A write to a high-half view (1, 3 or 5) in 32-bit mode sets offset bits 63:32 to bits 63:32 of ({req_wdata[31:0], 32'h0} - base). Offset bits 31:0 are kept.
- R5: The cycle views (2, 3) and the instret views (4, 5) use one shared offset, measured against retired_count. A write through one of these views is seen through the other.
- R6: View 6 returns rtc_count, fitted to the mode as in R2. View 7 returns rtc_count[63:32]. Writes to views 6 and 7 change no offset and are not illegal.
- R7: In 32-bit mode a high-half read returns bits 63:32 of the base-plus-offset sum, zero-extended. In 64-bit mode any access to views 1, 3 or 5 is illegal.
- R8: An illegal access gives rsp_illegal high for its one response cycle, with rsp_rdata zero, and changes no offset. A legal write response has rsp_illegal low and rsp_rdata zero.
- R9: After reset both offsets are zero and no response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | 1 selects 32-bit register width, 0 selects 64-bit |
| rtc_count | input | 64 | Free-running real-time counter |
| retired_count | input | 64 | Retired-instruction count |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_view | input | 3 | View code (0 to 7) |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_illegal | output | 1 | The previous request was illegal |
| rsp_rdata | output | 64 | Read data (zero for writes and illegal accesses) |

## Verification
The assertions check on every cycle that responses follow requests one cycle later and appear only then. They check that a wide-mode high-half access always faults with zero data, that a machine time read mirrors the raw counter, that machine time writes leave the offsets stable, and that the half of an offset a narrow write does not touch stays fixed. Only the bench's scenarios can show that the offset arithmetic is right. Those scenarios cover borrows across the half boundary, the wrap at 2^64, the cycle/instret sharing, and the offset following a moving base on later reads. The bench sweeps every view, both modes, reads and writes, and counter patterns around the carry points.

// File: rtl/user_ctr_pkg.sv
package user_ctr_pkg;
    parameter int XW = 64;
    localparam int HW = XW / 2;
    localparam int NOFS = 2;

    typedef enum logic [2:0] {
        V_TIME     = 3'd0,
        V_TIME_HI  = 3'd1,
        V_CYCLE    = 3'd2,
        V_CYCLE_HI = 3'd3,
        V_INSTR    = 3'd4,
        V_INSTR_HI = 3'd5,
        V_MTIME    = 3'd6,
        V_MTIME_HI = 3'd7
    } view_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/ctr_view_decode.sv
module ctr_view_decode
    import user_ctr_pkg::*;
#(
    parameter int NO = NOFS
) (
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [2:0]    req_view,
    input  logic          narrow,
    output logic          legal,
    output logic          sel_inst,
    output logic          sel_hi,
    output logic          sel_mach,
    output logic [NO-1:0] wr_full,
    output logic [NO-1:0] wr_high
);
    view_e v;
    logic  do_wr;

    always_comb begin
        v        = view_e'(req_view);
        sel_hi   = 1'b0;
        sel_inst = 1'b0;
        sel_mach = 1'b0;
        unique case (v)
            V_TIME:     ;
            V_TIME_HI:  sel_hi = 1'b1;
            V_CYCLE,
            V_INSTR:    sel_inst = 1'b1;
            V_CYCLE_HI,
            V_INSTR_HI: begin sel_inst = 1'b1; sel_hi = 1'b1; end
            V_MTIME:    sel_mach = 1'b1;
            V_MTIME_HI: begin sel_mach = 1'b1; sel_hi = 1'b1; end
            default:    ;
        endcase
        legal = !(sel_hi && !sel_mach && !narrow);
        do_wr = req_valid && req_write && legal && !sel_mach;
        for (int k = 0; k < NO; k++) begin
            wr_full[k] = do_wr && !sel_hi && (sel_inst == (k == 1));
            wr_high[k] = do_wr &&  sel_hi && (sel_inst == (k == 1));
        end
    end
endmodule

// File: rtl/ctr_offset_reg.sv
module ctr_offset_reg
    import user_ctr_pkg::*;
#(
    parameter int W  = XW,
    localparam int H = W / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         narrow,
    input  logic         wr_full,
    input  logic         wr_high,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] base,
    output logic [W-1:0] ofs
);
    logic [W-1:0] diff;
    logic [H-1:0] hdiff;
    logic         lo_borrow;

    always_comb begin
        diff      = wdata - base;
        lo_borrow = (base[H-1:0] != '0);
        hdiff     = wdata[H-1:0] - base[W-1:H] - {{(H-1){1'b0}}, lo_borrow};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (wr_full) begin
            if (narrow) ofs[H-1:0] <= diff[H-1:0];
            else        ofs <= diff;
        end else if (wr_high) begin
            ofs[W-1:H] <= hdiff;
        end
    end

    AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wr_high && !wr_full |=> $stable(ofs[H-1:0])); // R4
    AST_NARROW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && wr_full && narrow |=> $stable(ofs[W-1:H])); // R3
    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !wr_full && !wr_high |=> $stable(ofs)); // R8
endmodule

// File: rtl/user_ctr_offset.sv
module user_ctr_offset
    import user_ctr_pkg::*;
#(
    parameter int W  = XW,
    localparam int H = W / 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode32,
    input  logic [W-1:0] rtc_count,
    input  logic [W-1:0] retired_count,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [2:0]   req_view,
    input  logic [W-1:0] req_wdata,
    output logic         rsp_valid,
    output logic         rsp_illegal,
    output logic [W-1:0] rsp_rdata
);
    rsp_state_e state_q, state_d;

    logic            legal, sel_inst, sel_hi, sel_mach;
    logic [NOFS-1:0] wr_full, wr_high;
    logic [W-1:0]    base [NOFS];
    logic [W-1:0]    ofs_q [NOFS];
    logic [W-1:0]    sum, src, rd_val, data_d;

    ctr_view_decode #(.NO(NOFS)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_view  (req_view),
        .narrow    (mode32),
        .legal     (legal),
        .sel_inst  (sel_inst),
        .sel_hi    (sel_hi),
        .sel_mach  (sel_mach),
        .wr_full   (wr_full),
        .wr_high   (wr_high)
    );

    assign base[0] = rtc_count;
    assign base[1] = retired_count;

    for (genvar g = 0; g < NOFS; g++) begin : g_ofs
        ctr_offset_reg #(.W(W)) u_ofs (
            .clk     (clk),
            .rst_n   (rst_n),
            .narrow  (mode32),
            .wr_full (wr_full[g]),
            .wr_high (wr_high[g]),
            .wdata   (req_wdata),
            .base    (base[g]),
            .ofs     (ofs_q[g])
        );
    end

    always_comb begin
        sum = sel_inst ? (retired_count + ofs_q[1]) : (rtc_count + ofs_q[0]);
        src = sel_mach ? rtc_count : sum;
        if (sel_hi)      rd_val = {{H{1'b0}}, src[W-1:H]};
        else if (mode32) rd_val = {{H{1'b0}}, src[H-1:0]};
        else             rd_val = src;
        data_d = (req_valid && !req_write && legal) ? rd_val : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (req_valid) state_d = legal ? ST_DONE : ST_FAULT;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_rdata <= '0;
        else        rsp_rdata <= data_d;
    end

    always_comb begin
        rsp_valid   = 1'b0;
        rsp_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  rsp_valid = 1'b1;
            ST_FAULT: begin rsp_valid = 1'b1; rsp_illegal = 1'b1; end
            default:  ;
        endcase
    end

    AST_NO_REQ_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !req_valid |=> !rsp_valid); // R1
    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid |=> rsp_valid); // R1
    AST_WIDE_HI_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid && !mode32 && req_view[0] && req_view != 3'd7 |=> rsp_illegal); // R7
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> rsp_rdata == '0); // R8
    AST_MTIME_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid && !req_write && !mode32 && req_view == 3'd6
        |=> rsp_rdata == $past(rtc_count)); // R6
    AST_MTIME_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && req_valid && req_write && req_view[2:1] == 2'b11
        |=> $stable(ofs_q[0]) && $stable(ofs_q[1])); // R6
endmodule

// File: tb/test_user_ctr_offset.sv
module test_user_ctr_offset;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b0;
    logic [63:0] rtc_count = '0, retired_count = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_view = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_illegal;
    logic [63:0] rsp_rdata;

    int errors = 0, checks = 0;
    logic [63:0] m_tofs = '0, m_iofs = '0;
    logic [63:0] pat [4];

    user_ctr_offset i_user_ctr_offset (
        .clk(clk), .rst_n(rst_n), .mode32(mode32),
        .rtc_count(rtc_count), .retired_count(retired_count),
        .req_valid(req_valid), .req_write(req_write), .req_view(req_view),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] fit(input logic [63:0] x, input logic hi, input logic n);
        if (hi) return {32'h0, x[63:32]};
        if (n)  return {32'h0, x[31:0]};
        return x;
    endfunction

    task automatic access(input logic wr, input logic [2:0] v, input logic [63:0] d);
        logic        hi, inst, mach, ill;
        logic [63:0] sum, exp, b, diff;
        logic [63:0] hv;
        string       tag;
        hi   = v[0];
        inst = (v == 3'd2) || (v == 3'd3) || (v == 3'd4) || (v == 3'd5);
        mach = (v == 3'd6) || (v == 3'd7);
        ill  = hi && !mach && !mode32;
        if (mach)      tag = "R6";
        else if (ill)  tag = "R7_R8";
        else if (inst) tag = "R5";
        else if (hi)   tag = wr ? "R4" : "R7";
        else           tag = wr ? "R3" : "R2";
        b   = inst ? retired_count : rtc_count;
        sum = b + (inst ? m_iofs : m_tofs);
        exp = (wr || ill) ? 64'h0 : fit(mach ? rtc_count : sum, hi, mode32);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_view = v; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, {tag, "_R1 valid"}, {63'h0, rsp_valid}, 64'h1);
        chk(rsp_illegal === ill, {tag, " illegal"}, {63'h0, rsp_illegal}, {63'h0, ill});
        chk(rsp_rdata === exp, {tag, " data"}, rsp_rdata, exp);
        if (wr && !ill && !mach) begin
            diff = d - b;
            hv   = {d[31:0], 32'h0} - b;
            if (inst) begin
                if (hi)          m_iofs[63:32] = hv[63:32];
                else if (mode32) m_iofs[31:0]  = diff[31:0];
                else             m_iofs        = diff;
            end else begin
                if (hi)          m_tofs[63:32] = hv[63:32];
                else if (mode32) m_tofs[31:0]  = diff[31:0];
                else             m_tofs        = diff;
            end
        end
    endtask

    initial begin
        pat[0] = 64'h0;
        pat[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pat[2] = 64'h0000_0001_0000_0000;
        pat[3] = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R9 no response in reset", {63'h0, rsp_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R9_R1 idle after reset", {63'h0, rsp_valid}, 64'h0);
        rtc_count = 64'h0000_00AB_0000_0010;
        retired_count = 64'h77;
        access(1'b0, 3'd0, '0);   // R9 zero offset: reads raw rtc
        access(1'b0, 3'd4, '0);   // R9
        for (int m = 0; m < 2; m++) begin
            mode32 = m[0];
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 4; p++) begin
                    rtc_count     = pat[(p + 1) % 4];
                    retired_count = pat[(p + 2) % 4];
                    access(1'b1, s[2:0], pat[p] ^ {32'h0, s[2:0], 29'h5});
                    @(negedge clk);
                    chk(rsp_valid === 1'b0, "R1 no request no response", {63'h0, rsp_valid}, 64'h0);
                    for (int r = 0; r < 8; r++) begin
                        rtc_count     = rtc_count + 64'h0000_0000_FFFF_FFF3;
                        retired_count = retired_count + 64'd5;
                        access(1'b0, r[2:0], '0);
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule